// File: doc/BRIEF.md
# Standard-Definition Serial Video Oversampler

This block sits between a standard-definition serial video datapath and a multi-gigabit transmitter. The transmitter serializes a 20-bit word on every edge of a single 54 MHz clock, which gives a line rate of 1.08 Gb/s. That is four times the 270 Mb/s standard-definition rate, so the block repeats each video bit four times. The transmitter then carries the slower stream with no second clock domain.

The block generates a clock enable that is high on every other 54 MHz cycle, so the upstream datapath advances at 27 MHz. On an enabled cycle the block takes one 10-bit scrambled word. Over the next two cycles it emits 40 output bits, each source bit repeated four times, least significant bit first.

A mode select switches the block to high-definition pass-through. In that mode the enable stays high and a full 20-bit word moves from input to output on every cycle.

The output word is never stalled. The transmitter takes one word on every clock. The enable `ce` is the only flow control: it works as the ready signal toward the source. The source must present a valid word whenever `ce` is high, and the block ignores the input while `ce` is low.

Top module: `sd_oversampler`

## Requirements
- R1: In standard-definition mode (`hd_sel`=0), `ce` alternates high and low on consecutive clock cycles.
- R2: While `rst` is high, `tx_word` is 0 and `ce` is high. The first cycle after `rst` falls is an enabled cycle.
- R3: On the cycle after an enabled standard-definition cycle, `tx_word[i]` equals the accepted `in_word[i/4]` for i = 0..19 (source bits 0..4, each repeated four times, bit 0 in the lowest positions).
- R4: On the second cycle after an enabled standard-definition cycle, `tx_word[i]` equals the accepted `in_word[5 + i/4]` for i = 0..19.
- R5: A change on `in_word` while `ce` is low has no effect on any later `tx_word` value.
- R6: In high-definition mode (`hd_sel`=1), `ce` is high on every cycle and `tx_word` equals the `in_word` of the previous cycle (all 20 bits).
- R7: On the first standard-definition cycle after high-definition mode, `ce` is high.
- R8: Taking every fourth bit of the serial output (bits 0, 4, 8, 12, 16 of each word, LSB first) returns the accepted 10-bit words in order and unaltered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single 54 MHz transmit clock |
| rst | input | 1 | Synchronous reset, active high |
| hd_sel | input | 1 | 1 = high-definition pass-through, 0 = standard-definition oversampling |
| in_word | input | 20 | Input word; only bits 9:0 are used in standard-definition mode |
| ce | output | 1 | Clock enable and input ready for the upstream datapath |
| tx_word | output | 20 | Word to the transmitter, one per clock |

## Verification
Some properties are checked by assertions on every cycle: the enable alternating, the enable after reset and after a return from high-definition mode, the content of each half word against the captured input, and the one-cycle pass-through in high-definition mode. Other behaviour shows only in the bench's scenarios. One is the sweep of all 1024 input words with each word recovered by decimation. Another is the stimulus that changes the input while the enable is low and then confirms that the output is unaffected. The last is mode switching in the middle of a stream.

// File: rtl/sdo_pkg.sv
package sdo_pkg;
  localparam int unsigned SDO_SD_W  = 10;
  localparam int unsigned SDO_REP   = 4;

  typedef enum logic {
    SDO_MODE_SD = 1'b0,
    SDO_MODE_HD = 1'b1
  } sdo_mode_e;
endpackage

// File: rtl/sdo_ce_gen.sv
module sdo_ce_gen (
  input  logic clk,
  input  logic rst,
  input  logic hd,
  output logic ce
);
  // phase 0 = enabled cycle; held at 0 in reset and in HD mode
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst || hd) phase_q <= 1'b0;
    else           phase_q <= ~phase_q;
  end

  assign ce = hd | ~phase_q;
endmodule

// File: rtl/sdo_replicate.sv
module sdo_replicate #(
  parameter int unsigned IN_W = 5,
  parameter int unsigned REP  = 4
) (
  input  logic [IN_W-1:0]     bits_in,
  output logic [IN_W*REP-1:0] bits_out
);
  for (genvar g = 0; g < IN_W; g++) begin : g_bit
    assign bits_out[g*REP +: REP] = {REP{bits_in[g]}};
  end
endmodule

// File: rtl/sd_oversampler.sv
module sd_oversampler #(
  parameter int unsigned SD_W = sdo_pkg::SDO_SD_W,
  parameter int unsigned REP  = sdo_pkg::SDO_REP,
  localparam int unsigned HALF  = SD_W / 2,
  localparam int unsigned OUT_W = HALF * REP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hd_sel,
  input  logic [OUT_W-1:0] in_word,
  output logic             ce,
  output logic [OUT_W-1:0] tx_word
);
  import sdo_pkg::*;

  sdo_mode_e mode;
  assign mode = sdo_mode_e'(hd_sel);

  logic hd_on;
  assign hd_on = (mode == SDO_MODE_HD);

  logic [HALF-1:0]  hold_q;
  logic [OUT_W-1:0] rep_lo;
  logic [OUT_W-1:0] rep_hi;
  logic [OUT_W-1:0] tx_q;

  sdo_ce_gen u_ce (
    .clk (clk),
    .rst (rst),
    .hd  (hd_on),
    .ce  (ce)
  );

  sdo_replicate #(.IN_W(HALF), .REP(REP)) u_rep_lo (
    .bits_in  (in_word[HALF-1:0]),
    .bits_out (rep_lo)
  );

  sdo_replicate #(.IN_W(HALF), .REP(REP)) u_rep_hi (
    .bits_in  (hold_q),
    .bits_out (rep_hi)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q   <= '0;
      hold_q <= '0;
    end else if (hd_on) begin
      tx_q   <= in_word;
    end else if (ce) begin
      tx_q   <= rep_lo;
      hold_q <= in_word[SD_W-1:HALF];
    end else begin
      tx_q   <= rep_hi;
    end
  end

  assign tx_word = tx_q;
endmodule

// File: rtl/sdo_checker.sv
module sdo_checker #(
  parameter int unsigned SD_W = 10,
  parameter int unsigned REP  = 4,
  localparam int unsigned HALF  = SD_W / 2,
  localparam int unsigned OUT_W = HALF * REP
) (
  input logic             clk,
  input logic             rst,
  input logic             hd_sel,
  input logic [OUT_W-1:0] in_word,
  input logic             ce,
  input logic [OUT_W-1:0] tx_word
);
  function automatic logic [OUT_W-1:0] spread(input logic [HALF-1:0] v);
    logic [OUT_W-1:0] r;
    for (int i = 0; i < OUT_W; i++) r[i] = v[i/REP];
    return r;
  endfunction

  a_r1_ce_alternates: assert property (@(posedge clk) disable iff (rst)
    (!hd_sel && $past(!hd_sel) && $past(!rst)) |-> (ce != $past(ce)));

  a_r2_ce_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> ce);

  a_r3_low_half: assert property (@(posedge clk) disable iff (rst)
    (ce && !hd_sel) |=> (tx_word == spread($past(in_word[HALF-1:0]))));

  a_r4_high_half: assert property (@(posedge clk) disable iff (rst)
    (!hd_sel && $past(ce && !hd_sel) && $past(!rst))
      |=> (tx_word == spread($past(in_word[SD_W-1:HALF], 2))));

  a_r6_hd_pass: assert property (@(posedge clk) disable iff (rst)
    hd_sel |=> (tx_word == $past(in_word)));

  a_r7_ce_after_hd: assert property (@(posedge clk) disable iff (rst)
    (!hd_sel && $past(hd_sel) && $past(!rst)) |-> ce);
endmodule

bind sd_oversampler sdo_checker #(.SD_W(SD_W), .REP(REP)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .hd_sel  (hd_sel),
  .in_word (in_word),
  .ce      (ce),
  .tx_word (tx_word)
);

// File: tb/sd_oversampler_bench.sv
module sd_oversampler_bench;
  localparam int W = 20;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         hd_sel = 1'b0;
  logic [W-1:0] in_word = '0;
  logic         ce;
  logic [W-1:0] tx_word;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sd_oversampler u_sd_oversampler (
    .clk(clk), .rst(rst), .hd_sel(hd_sel),
    .in_word(in_word), .ce(ce), .tx_word(tx_word)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expand(input logic [9:0] w, input int base);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = w[base + i/4];
    return r;
  endfunction

  // sends word w on the current (enabled) cycle; checks both halves and decimation
  task automatic send_sd(input logic [9:0] w, input bit disturb);
    logic [9:0] rec;
    check("R1 ce high before send", {19'd0, ce}, 20'd1);
    in_word = {10'h3A5, w};
    @(negedge clk);
    check("R3 low half", tx_word, expand(w, 0));
    check("R1 ce low", {19'd0, ce}, 20'd0);
    for (int k = 0; k < 5; k++) rec[k] = tx_word[4*k];
    if (disturb) in_word = ~in_word;
    @(negedge clk);
    check(disturb ? "R5 high half after disturb" : "R4 high half", tx_word, expand(w, 5));
    for (int k = 0; k < 5; k++) rec[5+k] = tx_word[4*k];
    check("R8 decimated word", {10'd0, rec}, {10'd0, w});
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 tx zero in reset", tx_word, '0);
    check("R2 ce high in reset", {19'd0, ce}, 20'd1);
    rst = 1'b0;
    check("R2 first cycle enabled", {19'd0, ce}, 20'd1);

    for (int w = 0; w < 1024; w++) send_sd(w[9:0], 1'b0);
    for (int w = 0; w < 16; w++) send_sd(10'(w * 67 + 5), 1'b1);

    hd_sel = 1'b1;
    for (int i = 0; i < 64; i++) begin
      logic [W-1:0] v;
      v = W'((i * 40503 + 12345) ^ (i << 9));
      in_word = v;
      @(negedge clk);
      check("R6 hd pass", tx_word, v);
      check("R6 hd ce", {19'd0, ce}, 20'd1);
    end
    hd_sel = 1'b0;
    check("R7 ce after hd", {19'd0, ce}, 20'd1);
    send_sd(10'h2C3, 1'b0);
    send_sd(10'h13C, 1'b1);

    rst = 1'b1;
    @(negedge clk);
    check("R2 tx cleared by reset", tx_word, '0);
    rst = 1'b0;
    send_sd(10'h3FF, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule